// File: doc/BRIEF.md
# Timing Register Load Port

This block is the host side of a programmable video timing generator. A host presents bytes on an 8-bit bus and pulses a load strobe. Two mode lines, sampled on the strobe's falling edge, pick the kind of cycle. An address cycle selects one of nineteen 12-bit registers. A data cycle writes either the low byte or the upper nibble of the selected register. The block presents the whole register bank to the timing logic as one flat vector.

An address cycle taken with the high-byte line set also turns on auto-load. In that mode the data cycles alternate between low byte and high nibble on their own. After each high nibble the address advances, and after the last register it returns to register 0. This lets a host stream the whole bank after a single address cycle.

The strobe is asynchronous to the pixel clock. Each completed data cycle flips a toggle, and a two-stage synchronizer carries that toggle into the pixel-clock domain, where the bank is updated. Because the write fields stay held until the next data cycle, consecutive data cycles must be at least four pixel clocks apart. Clear is asynchronous and restores every register to its built-in value. One parameter picks whether the status register comes up with the clock-enable bit set.

Top module: `timing_reg_loader`

## Requirements
- R1: While rst_ni is low, and afterwards until the first data write, the registers hold their built-in values. Register 0 (status) holds 0x000, and registers 1 to 18 hold 0x018, 0x05A, 0x0A9, 0x38E, 0x007, 0x00D, 0x029, 0x20D, 0x03C, 0x1AA, 0x001, 0x013, 0x001, 0x005, 0x0C8, 0x0D0, 0x064 and 0x06E in that order. Clear also returns the address to 0 and turns auto-load off.
- R2: A cycle with sel_data_i=0 loads data_i into the address register and writes no register.
- R3: A cycle with sel_data_i=1 and sel_high_i=0 writes data_i into bits 7:0 of the addressed register and leaves bits 11:8 unchanged.
- R4: A cycle with sel_data_i=1 and sel_high_i=1 writes data_i[3:0] into bits 11:8 of the addressed register and leaves bits 7:0 unchanged.
- R5: The mode lines are sampled on the falling edge of load_i. A change on them between that falling edge and the next rising edge does not change the cycle type.
- R6: An address cycle with sel_high_i=1 enables auto-load. The data cycles that follow write low, high, low, high and so on, whatever sel_high_i is. The address increments after each high write. An address cycle with sel_high_i=0 disables auto-load.
- R7: In auto-load, the address after a high write to register 18 (or to any address above it) is 0.
- R8: A data write to an address above 18 leaves every register unchanged.
- R9: Status bit 11 (counter test) always reads 0. A high write to register 0 forces it to 0.
- R10: A data write appears on regs_o at the third rising edge of clk_i after the rising edge of load_i, and not before. Data cycles are spaced at least four clk_i periods apart.
- R11: With parameter CLK_EN_RESET=1, the status register resets to 0x400 (bit 10, clock enable, set). The other registers keep the same built-in values as with CLK_EN_RESET=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock, the domain in which the register bank lives |
| rst_ni | input | 1 | Asynchronous clear, active low, restores built-in values |
| load_i | input | 1 | Load strobe, idle high: mode lines sampled on fall, data on rise |
| sel_data_i | input | 1 | 0: address cycle, 1: data cycle |
| sel_high_i | input | 1 | Data cycle: 0 low byte, 1 high nibble; address cycle: 1 enables auto-load |
| data_i | input | 8 | Host data bus |
| regs_o | output | 228 | Register bank, register k at bits [12k+11:12k] |

## Verification
A register write is expected on regs_o three clk_i rising edges after the strobe's rising edge. The latency check therefore raises the strobe just after a clock edge. It samples on the falling clock edge after the second edge, where the old value must still show, and again after the third edge, where the new value must show. Every other check waits six clock periods after the strobe's rising edge before sampling. This leaves the synchronizer settled well past the three-edge latency. Clear acts at once, so the reset values are sampled while clear is still held low.

// File: rtl/trl_pkg.sv
package trl_pkg;
  localparam int unsigned CLK_EN_BIT = 10;
  localparam int unsigned TEST_BIT   = 11;

  function automatic logic [11:0] mask_default(input int unsigned idx, input bit clk_en);
    case (idx)
      0:       return clk_en ? 12'h400 : 12'h000;
      1:       return 12'h018;
      2:       return 12'h05A;
      3:       return 12'h0A9;
      4:       return 12'h38E;
      5:       return 12'h007;
      6:       return 12'h00D;
      7:       return 12'h029;
      8:       return 12'h20D;
      9:       return 12'h03C;
      10:      return 12'h1AA;
      11:      return 12'h001;
      12:      return 12'h013;
      13:      return 12'h001;
      14:      return 12'h005;
      15:      return 12'h0C8;
      16:      return 12'h0D0;
      17:      return 12'h064;
      18:      return 12'h06E;
      default: return 12'h000;
    endcase
  endfunction
endpackage

// File: rtl/trl_host_port.sv
module trl_host_port #(
  parameter int unsigned NUM_REGS = 19,
  parameter int unsigned BUS_W    = 8
) (
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             sel_data_i,
  input  logic             sel_high_i,
  input  logic [BUS_W-1:0] data_i,
  output logic             wr_tgl_o,
  output logic [BUS_W-1:0] wr_addr_o,
  output logic             wr_high_o,
  output logic [BUS_W-1:0] wr_byte_o
);
  localparam logic [BUS_W-1:0] LAST = BUS_W'(NUM_REGS - 1);

  logic             is_data_q, hsel_q;
  logic [BUS_W-1:0] addr_q;
  logic             auto_q, phase_q;
  logic             tgl_q, high_q;
  logic [BUS_W-1:0] waddr_q, wbyte_q;

  // mode lines sampled on the falling edge of the strobe
  always_ff @(negedge load_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_data_q <= 1'b0;
      hsel_q    <= 1'b0;
    end else begin
      is_data_q <= sel_data_i;
      hsel_q    <= sel_high_i;
    end
  end

  always_ff @(posedge load_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      auto_q  <= 1'b0;
      phase_q <= 1'b0;
      tgl_q   <= 1'b0;
      high_q  <= 1'b0;
      waddr_q <= '0;
      wbyte_q <= '0;
    end else if (!is_data_q) begin
      addr_q  <= data_i;
      auto_q  <= hsel_q;
      phase_q <= 1'b0;
    end else begin
      waddr_q <= addr_q;
      wbyte_q <= data_i;
      high_q  <= auto_q ? phase_q : hsel_q;
      tgl_q   <= ~tgl_q;
      if (auto_q) begin
        phase_q <= ~phase_q;
        if (phase_q) addr_q <= (addr_q >= LAST) ? '0 : addr_q + BUS_W'(1);
      end
    end
  end

  assign wr_tgl_o  = tgl_q;
  assign wr_addr_o = waddr_q;
  assign wr_high_o = high_q;
  assign wr_byte_o = wbyte_q;

  // R6
  auto_incr_chk: assert property (@(posedge load_i) disable iff (!rst_ni)
    (is_data_q && auto_q && phase_q && addr_q < LAST) |=> (addr_q == $past(addr_q) + BUS_W'(1)));
  // R7
  auto_wrap_chk: assert property (@(posedge load_i) disable iff (!rst_ni)
    (is_data_q && auto_q && phase_q && addr_q >= LAST) |=> (addr_q == '0));
  // R6
  auto_lowfirst_chk: assert property (@(posedge load_i) disable iff (!rst_ni)
    (!is_data_q) |=> !phase_q);
endmodule

// File: rtl/trl_tgl_sync.sv
module trl_tgl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q[0] <= 1'b0;
    else         q[0] <= tgl_i;
  end

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[s] <= 1'b0;
      else         q[s] <= q[s-1];
    end
  end

  assign pulse_o = q[STAGES-1] ^ q[STAGES];

  // R10
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/trl_reg_bank.sv
module trl_reg_bank
  import trl_pkg::*;
#(
  parameter int unsigned NUM_REGS     = 19,
  parameter int unsigned REG_W        = 12,
  parameter int unsigned BUS_W        = 8,
  parameter bit          CLK_EN_RESET = 1'b0,
  localparam int unsigned HI_W        = REG_W - BUS_W,
  localparam int unsigned FLAT_W      = NUM_REGS * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_pulse_i,
  input  logic [BUS_W-1:0]  wr_addr_i,
  input  logic              wr_high_i,
  input  logic [BUS_W-1:0]  wr_byte_i,
  output logic [FLAT_W-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [REG_W-1:0] DEF = REG_W'(mask_default(g, CLK_EN_RESET));
    // status register keeps the test bit cleared
    localparam logic [HI_W-1:0] HI_MASK =
      (g == 0) ? ~(HI_W'(1) << (TEST_BIT - BUS_W)) : '1;

    logic [REG_W-1:0] r_q;
    logic             hit;
    assign hit = wr_pulse_i && (wr_addr_i == BUS_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        r_q <= DEF;
      else if (hit) begin
        if (wr_high_i)    r_q[REG_W-1:BUS_W] <= wr_byte_i[HI_W-1:0] & HI_MASK;
        else              r_q[BUS_W-1:0]     <= wr_byte_i;
      end
    end

    assign regs_o[g*REG_W +: REG_W] = r_q;
  end

  // R8
  bad_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pulse_i && wr_addr_i >= BUS_W'(NUM_REGS)) |=> $stable(regs_o));
  // R10
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_pulse_i |=> $stable(regs_o));
  // R9
  test_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !regs_o[TEST_BIT]);
endmodule

// File: rtl/timing_reg_loader.sv
module timing_reg_loader #(
  parameter int unsigned NUM_REGS     = 19,
  parameter int unsigned REG_W        = 12,
  parameter int unsigned BUS_W        = 8,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter bit          CLK_EN_RESET = 1'b0,
  localparam int unsigned FLAT_W      = NUM_REGS * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              sel_data_i,
  input  logic              sel_high_i,
  input  logic [BUS_W-1:0]  data_i,
  output logic [FLAT_W-1:0] regs_o
);
  logic             wr_tgl, wr_high, wr_pulse;
  logic [BUS_W-1:0] wr_addr, wr_byte;

  trl_host_port #(.NUM_REGS(NUM_REGS), .BUS_W(BUS_W)) host_i (
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .sel_data_i (sel_data_i),
    .sel_high_i (sel_high_i),
    .data_i     (data_i),
    .wr_tgl_o   (wr_tgl),
    .wr_addr_o  (wr_addr),
    .wr_high_o  (wr_high),
    .wr_byte_o  (wr_byte)
  );

  trl_tgl_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tgl_i   (wr_tgl),
    .pulse_o (wr_pulse)
  );

  trl_reg_bank #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .BUS_W(BUS_W), .CLK_EN_RESET(CLK_EN_RESET)
  ) bank_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_pulse_i (wr_pulse),
    .wr_addr_i  (wr_addr),
    .wr_high_i  (wr_high),
    .wr_byte_i  (wr_byte),
    .regs_o     (regs_o)
  );
endmodule

// File: tb/timing_reg_loader_tb.sv
module timing_reg_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 19;

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b1, sel_data = 1'b0, sel_high = 1'b0;
  logic [7:0] data = '0;
  logic [NR*12-1:0] regs_a, regs_b;
  int errors = 0, checks = 0;

  logic [11:0] exp_r [NR];
  int m_addr;
  bit m_auto, m_phase;

  always #(CLK_PERIOD/2) clk = ~clk;

  timing_reg_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .sel_data_i(sel_data),
    .sel_high_i(sel_high), .data_i(data), .regs_o(regs_a));

  timing_reg_loader #(.CLK_EN_RESET(1'b1)) dut_r_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .sel_data_i(sel_data),
    .sel_high_i(sel_high), .data_i(data), .regs_o(regs_b));

  function automatic logic [11:0] dflt(int k);
    logic [11:0] t [NR] = '{12'h000, 12'h018, 12'h05A, 12'h0A9, 12'h38E, 12'h007, 12'h00D,
                            12'h029, 12'h20D, 12'h03C, 12'h1AA, 12'h001, 12'h013, 12'h001,
                            12'h005, 12'h0C8, 12'h0D0, 12'h064, 12'h06E};
    return t[k];
  endfunction

  task automatic model_clear();
    for (int k = 0; k < NR; k++) exp_r[k] = dflt(k);
    m_addr = 0; m_auto = 0; m_phase = 0;
  endtask

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%03h expected=0x%03h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int k = 0; k < NR; k++) check(req, regs_a[k*12 +: 12], exp_r[k]);
  endtask

  // one strobe; flip changes the mode lines between fall and rise
  task automatic strobe(bit d, bit h, logic [7:0] v, bit flip);
    sel_data = d; sel_high = h; data = v;
    #4 load = 1'b0;
    #4 if (flip) begin sel_data = ~d; sel_high = ~h; end
    #4 load = 1'b1;
    repeat (6) @(negedge clk);
    if (!d) begin
      m_addr = v; m_auto = h; m_phase = 0;
    end else begin
      bit hi = m_auto ? m_phase : h;
      if (m_addr <= 18) begin
        if (hi) begin
          exp_r[m_addr][11:8] = v[3:0];
          if (m_addr == 0) exp_r[0][11] = 1'b0;
        end else exp_r[m_addr][7:0] = v;
      end
      if (m_auto) begin
        if (m_phase) m_addr = (m_addr >= 18) ? 0 : m_addr + 1;
        m_phase = ~m_phase;
      end
    end
  endtask

  initial begin
    model_clear();
    #(CLK_PERIOD*3);
    // R1 / R11 reset values, sampled while clear is held
    check_all("R1");
    check("R11", regs_b[11:0], 12'h400);
    check("R11", regs_b[4*12 +: 12], 12'h38E);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R3/R4 sweep of every register
    for (int i = 0; i < NR; i++) begin
      strobe(1'b0, 1'b0, 8'(i), 1'b0);
      check("R2", regs_a[i*12 +: 12], exp_r[i]);
      strobe(1'b1, 1'b0, 8'((i*29 + 7) & 255), 1'b0);
      check("R3", regs_a[i*12 +: 12], exp_r[i]);
      strobe(1'b1, 1'b1, 8'((i*53 + 3) & 255), 1'b0);
      check("R4", regs_a[i*12 +: 12], exp_r[i]);
    end
    check_all("R4");

    // R9 status test bit forced low
    strobe(1'b0, 1'b0, 8'd0, 1'b0);
    strobe(1'b1, 1'b1, 8'hFF, 1'b0);
    check("R9", regs_a[11:0], exp_r[0]);
    check("R9", {11'd0, regs_a[11]}, 12'h000);

    // R5 mode lines flipped after the falling edge
    strobe(1'b0, 1'b0, 8'd5, 1'b1);
    check_all("R5");
    strobe(1'b1, 1'b0, 8'hC3, 1'b1);
    check("R5", regs_a[5*12 +: 12], exp_r[5]);
    strobe(1'b1, 1'b0, 8'h3C, 1'b0);
    check("R5", regs_a[5*12 +: 12], exp_r[5]);

    // R8 writes above the last register
    strobe(1'b0, 1'b0, 8'd19, 1'b0);
    strobe(1'b1, 1'b0, 8'hAA, 1'b0);
    strobe(1'b1, 1'b1, 8'h0F, 1'b0);
    strobe(1'b0, 1'b0, 8'd200, 1'b0);
    strobe(1'b1, 1'b0, 8'h55, 1'b0);
    check_all("R8");

    // R6/R7 auto-load across the wrap
    strobe(1'b0, 1'b1, 8'd17, 1'b0);
    strobe(1'b1, 1'b1, 8'h11, 1'b0);
    check("R6", regs_a[17*12 +: 12], exp_r[17]);
    strobe(1'b1, 1'b0, 8'h02, 1'b0);
    check("R6", regs_a[17*12 +: 12], exp_r[17]);
    strobe(1'b1, 1'b1, 8'h33, 1'b0);
    strobe(1'b1, 1'b0, 8'h04, 1'b0);
    check("R6", regs_a[18*12 +: 12], exp_r[18]);
    strobe(1'b1, 1'b0, 8'h77, 1'b0);
    strobe(1'b1, 1'b0, 8'h0C, 1'b0);
    check("R7", regs_a[11:0], exp_r[0]);
    check("R7", regs_a[11:0], 12'h477);
    // auto-load off again
    strobe(1'b0, 1'b0, 8'd2, 1'b0);
    strobe(1'b1, 1'b1, 8'h09, 1'b0);
    strobe(1'b1, 1'b1, 8'h0A, 1'b0);
    check("R6", regs_a[2*12 +: 12], exp_r[2]);
    check_all("R6");

    // R10 latency: rise just after a clock edge
    strobe(1'b0, 1'b0, 8'd3, 1'b0);
    sel_data = 1'b1; sel_high = 1'b0; data = 8'h5A;
    #2 load = 1'b0;
    @(posedge clk); #1 load = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", regs_a[3*12 +: 12], exp_r[3]);
    exp_r[3][7:0] = 8'h5A;
    @(negedge clk);
    check("R10", regs_a[3*12 +: 12], exp_r[3]);
    repeat (4) @(negedge clk);

    // R1 clear mid-run, address and auto-load restored
    strobe(1'b0, 1'b1, 8'd9, 1'b0);
    rst_n = 1'b0;
    model_clear();
    #(CLK_PERIOD*2);
    check_all("R1");
    check("R11", regs_b[11:0], 12'h400);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    strobe(1'b1, 1'b0, 8'hE1, 1'b0);
    check("R1", regs_a[11:0], exp_r[0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule